// File: doc/BRIEF.md
# Compact RISC Execute Stage

This block is the execute stage of a small 32-bit load/store core. Each transfer carries one instruction word and the two operand values already read from the register file (the value of the first source register and the value of the second). The stage decodes the opcode and function fields, runs the selected arithmetic, logic, compare or upper-immediate operation, and returns the result, the destination register index and a write enable. For word loads and stores it returns the effective address and a load or store flag in place of a register write. Encodings outside the supported set raise an illegal flag with every side effect suppressed.

The input and output are valid/ready streams with one register between them. A transfer is accepted on a rising clock edge where `in_valid` and `in_ready` are both high, and its result is presented on the next cycle. The output holds steady while `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back transfers run at one per cycle and back-pressure stalls the input after one held result.

Top module: `cx_exec`

## Requirements
- R1: The instruction fields are opcode = bits 31:26, first source = bits 25:21, second source = bits 20:16, register-format destination = bits 15:11, function = bits 5:0, and immediate = bits 15:0. Register-format results use bits 15:11 as `out_dest`. Immediate-format results, loads and stores use bits 20:16.
- R2: For opcode 0, function 32 gives rs+rt and function 34 gives rs-rt, both modulo 2^32 with no trap.
- R3: For opcode 0, function 36 gives AND, 37 gives OR, 38 gives XOR and 39 gives the complement of the OR.
- R4: Function 42 (opcode 0) compares rs against rt, and opcode 10 compares rs against the sign-extended immediate. Both use a signed comparison and give the word 1 if rs is less, else 0.
- R5: Opcode 8 gives rs plus the sign-extended immediate, modulo 2^32.
- R6: Opcodes 12, 13 and 14 give AND, OR and XOR of rs with the zero-extended immediate.
- R7: Opcode 15 gives the immediate in bits 31:16 with bits 15:0 cleared.
- R8: Opcodes 35 (load) and 43 (store) give rs plus the sign-extended immediate on `out_result`, with `out_load` or `out_store` set and `out_wr_en` low. Every other legal operation sets `out_wr_en` and neither memory flag. At most one of the three is high.
- R9: Any other opcode, or opcode 0 with any other function code, sets `out_illegal` and clears `out_wr_en`, `out_load` and `out_store`.
- R10: A transfer accepted at one edge appears at the output after that edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold. When the held result is taken with no new input, `out_valid` falls.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Stage can accept a transfer |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of the first source register |
| in_rt_val | input | 32 | Value of the second source register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Operation result or effective address |
| out_dest | output | 5 | Destination register index |
| out_wr_en | output | 1 | Result is to be written to `out_dest` |
| out_load | output | 1 | Word load at `out_result` into `out_dest` |
| out_store | output | 1 | Word store to address `out_result` |
| out_illegal | output | 1 | Unsupported encoding |

## Verification
The bench sweeps all 64 opcodes and, under opcode 0, all 64 function codes. Each is tried against operands at the signed extremes, at zero and at all ones, and with immediates whose bit 15 is both clear and set. Zero-extending an arithmetic immediate, or sign-extending a logical one, shows up as wrong upper bits when the immediate is 0x8000 or 0xffff. An unsigned compare in place of a signed one gives the wrong answer for 0x80000000 against 1. A decoder that falls through on an unlisted code writes a register instead of raising the illegal flag. A stall test holds `out_ready` low with a second transfer waiting. It checks that the held result does not change and that the waiting transfer is neither lost nor taken twice.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

  localparam logic [OPC_W-1:0] FN_ADD = 6'd32;
  localparam logic [OPC_W-1:0] FN_SUB = 6'd34;
  localparam logic [OPC_W-1:0] FN_AND = 6'd36;
  localparam logic [OPC_W-1:0] FN_OR  = 6'd37;
  localparam logic [OPC_W-1:0] FN_XOR = 6'd38;
  localparam logic [OPC_W-1:0] FN_NOR = 6'd39;
  localparam logic [OPC_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             use_imm;
    logic             imm_sext;
    logic [REG_W-1:0] dest;
    logic             wr_en;
    logic             load;
    logic             store;
    logic             illegal;
  } dec_t;
endpackage

// File: rtl/cx_decode.sv
module cx_decode
  import cx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec,
  output logic [IMM_W-1:0]   imm
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] fn;
  logic [REG_W-1:0] rt_idx;
  logic [REG_W-1:0] rd_idx;

  assign opc    = instr[31:26];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign fn     = instr[5:0];
  assign imm    = instr[15:0];

  always_comb begin
    dec          = '0;
    dec.op       = ALU_ADD;
    dec.dest     = rt_idx;
    dec.wr_en    = 1'b1;
    dec.use_imm  = 1'b1;
    dec.imm_sext = 1'b1;
    unique case (opc)
      OPC_REG: begin
        dec.dest    = rd_idx;
        dec.use_imm = 1'b0;
        unique case (fn)
          FN_ADD:  dec.op = ALU_ADD;
          FN_SUB:  dec.op = ALU_SUB;
          FN_AND:  dec.op = ALU_AND;
          FN_OR:   dec.op = ALU_OR;
          FN_XOR:  dec.op = ALU_XOR;
          FN_NOR:  dec.op = ALU_NOR;
          FN_SLT:  dec.op = ALU_SLT;
          default: dec.illegal = 1'b1;
        endcase
      end
      OPC_ADDI: dec.op = ALU_ADD;
      OPC_SLTI: dec.op = ALU_SLT;
      OPC_ANDI: begin dec.op = ALU_AND; dec.imm_sext = 1'b0; end
      OPC_ORI:  begin dec.op = ALU_OR;  dec.imm_sext = 1'b0; end
      OPC_XORI: begin dec.op = ALU_XOR; dec.imm_sext = 1'b0; end
      OPC_LUI:  dec.op = ALU_LUI;
      OPC_LOAD:  begin dec.wr_en = 1'b0; dec.load  = 1'b1; end
      OPC_STORE: begin dec.wr_en = 1'b0; dec.store = 1'b1; end
      default:  dec.illegal = 1'b1;
    endcase
    if (dec.illegal) begin
      dec.wr_en = 1'b0;
      dec.load  = 1'b0;
      dec.store = 1'b0;
    end
  end
endmodule

// File: rtl/cx_datapath.sv
module cx_datapath
  import cx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e           op,
  input  logic              use_imm,
  input  logic              imm_sext,
  input  logic [IMM_W-1:0]  imm,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [XLEN-1:0]   result
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] opb_adj;
  logic [XLEN-1:0] sum;
  logic            is_sub;
  logic            lt;

  assign imm_ext = imm_sext ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
  assign opb     = use_imm ? imm_ext : rt_val;
  assign is_sub  = (op == ALU_SUB);
  assign opb_adj = is_sub ? ~opb : opb;
  assign sum     = rs_val + opb_adj + {{(XLEN-1){1'b0}}, is_sub};
  assign lt      = $signed(rs_val) < $signed(opb);

  always_comb begin
    unique case (op)
      ALU_ADD, ALU_SUB: result = sum;
      ALU_AND: result = rs_val & opb;
      ALU_OR:  result = rs_val | opb;
      ALU_XOR: result = rs_val ^ opb;
      ALU_NOR: result = ~(rs_val | opb);
      ALU_SLT: result = {{(XLEN-1){1'b0}}, lt};
      ALU_LUI: result = {imm, {EXT_W{1'b0}}};
      default: result = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_SLT) begin
      AST_SLT_IS_BOOL: assert (result[XLEN-1:1] == '0); // R4
    end
    if (op == ALU_LUI) begin
      AST_LUI_LOW_CLEAR: assert (result[EXT_W-1:0] == '0); // R7
    end
  end
endmodule

// File: rtl/cx_stage.sv
module cx_stage
  import cx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  dec_t             dec,
  input  logic [XLEN-1:0]  result,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [REG_W-1:0] out_dest,
  output logic             out_wr_en,
  output logic             out_load,
  output logic             out_store,
  output logic             out_illegal
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result  <= result;
      out_dest    <= dec.dest;
      out_wr_en   <= dec.wr_en;
      out_load    <= dec.load;
      out_store   <= dec.store;
      out_illegal <= dec.illegal;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dest)
      && $stable(out_wr_en) && $stable(out_illegal)); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wr_en && !out_load && !out_store); // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_wr_en, out_load, out_store})); // R8
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R10
endmodule

// File: rtl/cx_exec.sv
module cx_exec
  import cx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_instr,
  input  logic [XLEN-1:0]  in_rs_val,
  input  logic [XLEN-1:0]  in_rt_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [4:0]       out_dest,
  output logic             out_wr_en,
  output logic             out_load,
  output logic             out_store,
  output logic             out_illegal
);
  dec_t             dec;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  result;

  cx_decode u_decode (
    .instr (in_instr),
    .dec   (dec),
    .imm   (imm)
  );

  cx_datapath #(.XLEN(XLEN)) u_datapath (
    .op       (dec.op),
    .use_imm  (dec.use_imm),
    .imm_sext (dec.imm_sext),
    .imm      (imm),
    .rs_val   (in_rs_val),
    .rt_val   (in_rt_val),
    .result   (result)
  );

  cx_stage #(.XLEN(XLEN)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .dec         (dec),
    .result      (result),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_dest    (out_dest),
    .out_wr_en   (out_wr_en),
    .out_load    (out_load),
    .out_store   (out_store),
    .out_illegal (out_illegal)
  );
endmodule

// File: tb/tb_cx_exec.sv
`timescale 1ns/1ps
module tb_cx_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rs_val = '0;
  logic [31:0] in_rt_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wr_en, out_load, out_store, out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cx_exec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_dest(out_dest), .out_wr_en(out_wr_en), .out_load(out_load),
    .out_store(out_store), .out_illegal(out_illegal)
  );

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h12345678};
  logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'hc3a5};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] res, output logic [4:0] dst,
                       output logic [3:0] flags, output string req);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [15:0] im = ins[15:0];
    logic [31:0] sx = {{16{im[15]}}, im};
    logic [31:0] zx = {16'h0, im};
    res = '0; dst = ins[20:16]; flags = 4'b1000; req = "R9";
    case (op)
      6'd0: begin
        dst = ins[15:11];
        case (fn)
          6'd32: begin res = a + b; req = "R2"; end
          6'd34: begin res = a - b; req = "R2"; end
          6'd36: begin res = a & b; req = "R3"; end
          6'd37: begin res = a | b; req = "R3"; end
          6'd38: begin res = a ^ b; req = "R3"; end
          6'd39: begin res = ~(a | b); req = "R3"; end
          6'd42: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; req = "R4"; end
          default: flags = 4'b0001;
        endcase
      end
      6'd8:  begin res = a + sx; req = "R5"; end
      6'd10: begin res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; req = "R4"; end
      6'd12: begin res = a & zx; req = "R6"; end
      6'd13: begin res = a | zx; req = "R6"; end
      6'd14: begin res = a ^ zx; req = "R6"; end
      6'd15: begin res = {im, 16'h0}; req = "R7"; end
      6'd35: begin res = a + sx; flags = 4'b0100; req = "R8"; end
      6'd43: begin res = a + sx; flags = 4'b0010; req = "R8"; end
      default: flags = 4'b0001;
    endcase
  endtask

  task automatic xfer(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er; logic [4:0] ed; logic [3:0] ef; string rq;
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_rs_val = a; in_rt_val = b;
    @(negedge clk);
    in_valid = 1'b0;
    model(ins, a, b, er, ed, ef, rq);
    chk(out_valid === 1'b1, "R10", "valid one cycle later", {31'h0, out_valid}, 32'h1);
    chk({out_wr_en, out_load, out_store, out_illegal} === ef, rq, "flags",
        {28'h0, out_wr_en, out_load, out_store, out_illegal}, {28'h0, ef});
    if (!ef[0]) begin
      chk(out_result === er, rq, "result", out_result, er);
      chk(out_dest === ed, "R1", "dest", {27'h0, out_dest}, {27'h0, ed});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11", "valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", "valid after reset", {31'h0, out_valid}, 32'h0);
    chk(in_ready === 1'b1, "R11", "ready after reset", {31'h0, in_ready}, 32'h1);

    // R2 R3 R4 R9 R1: every function code under opcode 0
    for (int f = 0; f < 64; f++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          xfer({6'd0, 5'(i + 1), 5'(j + 9), 5'(i * 5 + j), 5'(j), 6'(f)}, vals[i], vals[j]);

    // R5 R6 R7 R8 R9 R1: every opcode with all immediates
    for (int o = 1; o < 64; o++)
      for (int i = 0; i < 6; i++)
        for (int k = 0; k < 6; k++)
          xfer({6'(o), 5'(i + 3), 5'(k + 20), imms[k]}, vals[i], vals[5 - k]);

    // R10: back-pressure holds the result and the waiting transfer
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = {6'd8, 5'd1, 5'd2, 16'h0010}; in_rs_val = 32'h100; in_rt_val = 0;
    @(negedge clk);
    in_instr = {6'd15, 5'd0, 5'd4, 16'hbeef};
    chk(out_result === 32'h110, "R10", "first result", out_result, 32'h110);
    chk(in_ready === 1'b0, "R10", "ready low in stall", {31'h0, in_ready}, 32'h0);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1 && out_result === 32'h110, "R10", "held result", out_result, 32'h110);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_result === 32'hbeef0000 && out_dest === 5'd4, "R10", "waiting transfer", out_result, 32'hbeef0000);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", "drained", {31'h0, out_valid}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule